// File: doc/BRIEF.md
# Low-Power Idle Mode Controller

This block decides when a small processor core is halted and whether it runs on its reduced clock. Software sets the idle request bit in a power-control register to halt the core. If the clock-mode register is nonzero at that moment, the core enters low-power idle. If the register is zero, it enters plain idle. The block also holds a watchdog-arm flag that software can clear but never set.

An enabled interrupt ends either idle state and clears the idle request bit. Waking from plain idle returns the core to normal running. Waking from low-power idle returns it only to low-power running. The core leaves low-power running for normal running only when software writes zero to the clock-mode register. The address of the instruction after the idle-setting write is kept, so execution can continue there once the interrupt has been serviced.

A reset request ends any state and asks the core to restart at address zero. A reset request is an internal or external request, or a watchdog reset while the watchdog is armed.

Top module: `lpidle_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `mode_state` is 00 (normal running), `cpu_halt`=0, `lp_clk`=0, `clk_mode`=0, `idle_sel`=0, `wdt_armed`=1, `restart_req`=0 and `wake_pulse`=0.
- R2: A write with `wr_sel`=0 and `wr_data[0]`=1 in a running state sets `idle_sel` and `cpu_halt` on the next clock. `mode_state` becomes 10 (idle) if `clk_mode` was zero, or 11 (low-power idle) otherwise. Such a write with `wr_data[0]`=0 has no effect.
- R3: A write with `wr_sel`=1 in a running state loads `clk_mode` on the next clock. `mode_state` becomes 01 (low-power running) if the data is nonzero, or 00 if it is zero. A zero write is the only way from 01 to 00.
- R4: Any set bit of `irq_req` in state 10 or 11 gives, on the next clock, `cpu_halt`=0, `idle_sel`=0, a one-cycle `wake_pulse`, and `clk_mode` unchanged. State 10 goes to 00 and state 11 goes to 01. In running states, `irq_req` has no effect.
- R5: `resume_addr` captures `pc_next` on the write that enters idle and holds that value through the wake-up.
- R6: `int_rst_req` or `ext_rst_req`, in any state, gives a one-cycle `restart_req` on the next clock with `restart_addr`=0. The same clock sets `mode_state`=00, `clk_mode`=0, `idle_sel`=0 and `wdt_armed`=1. A reset request wins over a simultaneous interrupt or write.
- R7: `wdt_rst` acts as a reset request (as in R6) only while `wdt_armed`=1. A write with `wr_sel`=2 and `wr_data[0]`=0 clears `wdt_armed`. Writing 1 there has no effect. A disarmed core stays idle with no time limit.
- R8: Register writes while `cpu_halt`=1 are ignored.
- R9: `cpu_halt` is `mode_state[1]` and `lp_clk` is `mode_state[0]`. Other than through R1 and R6, `restart_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 power control, 1 clock mode, 2 watchdog arm |
| wr_data | input | 8 | Write data |
| pc_next | input | 16 | Address following the current write instruction |
| irq_req | input | 4 | Enabled interrupt requests |
| int_rst_req | input | 1 | Internal reset request |
| ext_rst_req | input | 1 | External reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| cpu_halt | output | 1 | Core halted |
| lp_clk | output | 1 | Low-power clocking in force |
| mode_state | output | 2 | 00 run, 01 low-power run, 10 idle, 11 low-power idle |
| idle_sel | output | 1 | Idle request bit |
| clk_mode | output | 8 | Clock-mode register |
| wdt_armed | output | 1 | Watchdog reset enabled |
| wake_pulse | output | 1 | One-cycle pulse on an interrupt wake-up |
| resume_addr | output | 16 | Address to continue at after the interrupt |
| restart_req | output | 1 | One-cycle restart request |
| restart_addr | output | 16 | Restart address |

## Verification
Every state change is registered, so a wrong state shows on `mode_state`, `cpu_halt` and `lp_clk` exactly one clock after the triggering event. The case that matters most is an interrupt wake from low-power idle that lands in 00 instead of 01. That error shows as `lp_clk` dropping early, and no later zero write to the clock-mode register would be needed to reach 00. An arm flag that is wrongly cleared, or a watchdog reset that is ignored, shows as a missing `restart_req` or as `cpu_halt` staying high on the clock after `wdt_rst`.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_LPRUN  = 2'b01,
    ST_IDLE   = 2'b10,
    ST_LPIDLE = 2'b11
  } lpi_state_e;

  localparam logic [1:0] SEL_PWR = 2'd0;
  localparam logic [1:0] SEL_CLK = 2'd1;
  localparam logic [1:0] SEL_WDT = 2'd2;
endpackage

// File: rtl/lpi_rst_sync.sv
module lpi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lpi_wake_arb.sv
module lpi_wake_arb
  import lpi_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  lpi_state_e       state,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic             wr_bit0,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             int_rst_req,
  input  logic             ext_rst_req,
  input  logic             wdt_rst,
  input  logic             wdt_armed,
  output logic             rst_evt,
  output logic             irq_wake,
  output logic             clk_wr,
  output logic             wdt_wr,
  output logic             enter_idle
);
  logic sleeping;
  logic wr_ok;

  always_comb begin
    sleeping   = (state == ST_IDLE) || (state == ST_LPIDLE);
    rst_evt    = int_rst_req || ext_rst_req || (wdt_rst && wdt_armed);
    irq_wake   = sleeping && (|irq_req) && !rst_evt;
    wr_ok      = wr_en && !sleeping && !rst_evt;
    enter_idle = wr_ok && (wr_sel == SEL_PWR) && wr_bit0;
    clk_wr     = wr_ok && (wr_sel == SEL_CLK);
    wdt_wr     = wr_ok && (wr_sel == SEL_WDT);
  end
endmodule

// File: rtl/lpi_cfg_regs.sv
module lpi_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_evt,
  input  logic              irq_wake,
  input  logic              clk_wr,
  input  logic              wdt_wr,
  input  logic              enter_idle,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] pc_next,
  output logic [DATA_W-1:0] clk_mode_q,
  output logic              idle_q,
  output logic              wdt_armed_q,
  output logic [ADDR_W-1:0] resume_q,
  output logic              restart_q,
  output logic              wake_q
);
  logic [DATA_W-1:0] clk_mode_d;
  logic              clk_mode_en;
  logic              idle_d;
  logic              idle_en;
  logic              wdt_armed_d;
  logic              wdt_en;

  always_comb begin
    clk_mode_en = rst_evt || clk_wr;
    clk_mode_d  = rst_evt ? '0 : wr_data;
    idle_en     = rst_evt || irq_wake || enter_idle;
    idle_d      = !(rst_evt || irq_wake);
    wdt_en      = rst_evt || (wdt_wr && !wr_data[0]);
    wdt_armed_d = rst_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_mode_q  <= '0;
      idle_q      <= 1'b0;
      wdt_armed_q <= 1'b1;
      resume_q    <= '0;
      restart_q   <= 1'b0;
      wake_q      <= 1'b0;
    end else begin
      if (clk_mode_en) clk_mode_q  <= clk_mode_d;
      if (idle_en)     idle_q      <= idle_d;
      if (wdt_en)      wdt_armed_q <= wdt_armed_d;
      if (enter_idle)  resume_q    <= pc_next;
      restart_q <= rst_evt;
      wake_q    <= irq_wake;
    end
  end
endmodule

// File: rtl/lpi_state_fsm.sv
module lpi_state_fsm
  import lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_evt,
  input  logic       irq_wake,
  input  logic       enter_idle,
  input  logic       clk_wr,
  input  logic       clk_mode_nz,
  input  logic       wr_data_nz,
  output lpi_state_e state_q
);
  lpi_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (rst_evt) begin
      state_d = ST_RUN;
    end else if (irq_wake) begin
      state_d = (state_q == ST_LPIDLE) ? ST_LPRUN : ST_RUN;
    end else if (enter_idle) begin
      state_d = clk_mode_nz ? ST_LPIDLE : ST_IDLE;
    end else if (clk_wr) begin
      state_d = wr_data_nz ? ST_LPRUN : ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lpidle_ctrl.sv
module lpidle_ctrl
  import lpi_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int N_IRQ     = 4,
  parameter int SYNC_STG  = 2,
  parameter logic [15:0] RESET_VEC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              int_rst_req,
  input  logic              ext_rst_req,
  input  logic              wdt_rst,
  output logic              cpu_halt,
  output logic              lp_clk,
  output logic [1:0]        mode_state,
  output logic              idle_sel,
  output logic [DATA_W-1:0] clk_mode,
  output logic              wdt_armed,
  output logic              wake_pulse,
  output logic [ADDR_W-1:0] resume_addr,
  output logic              restart_req,
  output logic [ADDR_W-1:0] restart_addr
);
  logic       rst_core_n;
  lpi_state_e state_q;
  logic       rst_evt, irq_wake, clk_wr, wdt_wr, enter_idle;

  lpi_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  lpi_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .state(state_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit0(wr_data[0]),
    .irq_req(irq_req), .int_rst_req(int_rst_req), .ext_rst_req(ext_rst_req),
    .wdt_rst(wdt_rst), .wdt_armed(wdt_armed), .rst_evt(rst_evt),
    .irq_wake(irq_wake), .clk_wr(clk_wr), .wdt_wr(wdt_wr),
    .enter_idle(enter_idle)
  );

  lpi_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .rst_evt(rst_evt), .irq_wake(irq_wake),
    .clk_wr(clk_wr), .wdt_wr(wdt_wr), .enter_idle(enter_idle),
    .wr_data(wr_data), .pc_next(pc_next), .clk_mode_q(clk_mode),
    .idle_q(idle_sel), .wdt_armed_q(wdt_armed), .resume_q(resume_addr),
    .restart_q(restart_req), .wake_q(wake_pulse)
  );

  lpi_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .rst_evt(rst_evt), .irq_wake(irq_wake),
    .enter_idle(enter_idle), .clk_wr(clk_wr), .clk_mode_nz(|clk_mode),
    .wr_data_nz(|wr_data), .state_q(state_q)
  );

  assign mode_state   = state_q;
  assign cpu_halt     = (state_q == ST_IDLE) || (state_q == ST_LPIDLE);
  assign lp_clk       = (state_q == ST_LPRUN) || (state_q == ST_LPIDLE);
  assign restart_addr = ADDR_W'(RESET_VEC);
endmodule

// File: rtl/lpi_ctrl_chk.sv
module lpi_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int N_IRQ  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_IRQ-1:0]  irq_req,
  input logic              int_rst_req,
  input logic              ext_rst_req,
  input logic              wdt_rst,
  input logic              wdt_armed,
  input logic              cpu_halt,
  input logic              idle_sel,
  input logic [1:0]        mode_state,
  input logic [DATA_W-1:0] clk_mode,
  input logic              restart_req
);
  logic any_rst;
  assign any_rst = int_rst_req || ext_rst_req || (wdt_rst && wdt_armed);

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[0] && !cpu_halt && !any_rst)
      |=> (cpu_halt && idle_sel));

  // R4
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && (|irq_req) && !any_rst) |=> (!cpu_halt && !idle_sel));

  // R4
  lp_wake_lands_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'b11 && (|irq_req) && !any_rst) |=> (mode_state == 2'b01));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst_req || ext_rst_req)
      |=> (restart_req && mode_state == 2'b00 && clk_mode == '0 && wdt_armed));

  // R7
  disarmed_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_armed && cpu_halt && !int_rst_req && !ext_rst_req && irq_req == '0)
      |=> cpu_halt);

  // R8
  halted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !any_rst) |=> $stable(clk_mode));

  // R9
  halt_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt == mode_state[1]);
endmodule

bind lpidle_ctrl lpi_ctrl_chk #(.DATA_W(DATA_W), .N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .irq_req(irq_req), .int_rst_req(int_rst_req),
  .ext_rst_req(ext_rst_req), .wdt_rst(wdt_rst), .wdt_armed(wdt_armed),
  .cpu_halt(cpu_halt), .idle_sel(idle_sel), .mode_state(mode_state),
  .clk_mode(clk_mode), .restart_req(restart_req)
);

// File: tb/sim_lpidle_ctrl.sv
module sim_lpidle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] pc_next = 0;
  logic [3:0]  irq_req = 0;
  logic        int_rst_req = 0, ext_rst_req = 0, wdt_rst = 0;
  logic        cpu_halt, lp_clk, idle_sel, wdt_armed, wake_pulse, restart_req;
  logic [1:0]  mode_state;
  logic [7:0]  clk_mode;
  logic [15:0] resume_addr, restart_addr;

  int checks = 0;
  int failures = 0;

  logic [1:0]  m_mode;
  logic [7:0]  m_cm;
  logic        m_idle, m_wdt, m_rr, m_wk;
  logic [15:0] m_res;
  string       tag;

  always #10 clk = ~clk;

  lpidle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pc_next(pc_next), .irq_req(irq_req),
    .int_rst_req(int_rst_req), .ext_rst_req(ext_rst_req), .wdt_rst(wdt_rst),
    .cpu_halt(cpu_halt), .lp_clk(lp_clk), .mode_state(mode_state),
    .idle_sel(idle_sel), .clk_mode(clk_mode), .wdt_armed(wdt_armed),
    .wake_pulse(wake_pulse), .resume_addr(resume_addr),
    .restart_req(restart_req), .restart_addr(restart_addr)
  );

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic string classify();
    logic sleeping;
    sleeping = m_mode[1];
    if (int_rst_req || ext_rst_req) return "R6";
    if (wdt_rst && m_wdt) return "R7";
    if (sleeping && |irq_req) return "R4";
    if (sleeping && wdt_rst) return "R7";
    if (sleeping && wr_en) return "R8";
    if (wr_en && wr_sel == 2'd0) return "R2";
    if (wr_en && wr_sel == 2'd1) return "R3";
    if (wr_en && wr_sel == 2'd2) return "R7";
    return "R9";
  endfunction

  task automatic predict_and_step();
    logic rst_e, wake, wok;
    logic [1:0] n_mode; logic [7:0] n_cm; logic n_idle, n_wdt; logic [15:0] n_res;
    tag   = classify();
    rst_e = int_rst_req || ext_rst_req || (wdt_rst && m_wdt);
    wake  = m_mode[1] && (|irq_req) && !rst_e;
    wok   = wr_en && !m_mode[1] && !rst_e;
    n_mode = m_mode; n_cm = m_cm; n_idle = m_idle; n_wdt = m_wdt; n_res = m_res;
    if (rst_e) begin
      n_mode = 2'b00; n_cm = 0; n_idle = 0; n_wdt = 1;
    end else if (wake) begin
      n_mode = (m_mode == 2'b11) ? 2'b01 : 2'b00; n_idle = 0;
    end else if (wok && wr_sel == 2'd0 && wr_data[0]) begin
      n_mode = (m_cm != 0) ? 2'b11 : 2'b10; n_idle = 1; n_res = pc_next;
    end else if (wok && wr_sel == 2'd1) begin
      n_cm = wr_data; n_mode = (wr_data != 0) ? 2'b01 : 2'b00;
    end else if (wok && wr_sel == 2'd2 && !wr_data[0]) begin
      n_wdt = 0;
    end
    @(posedge clk);
    #2;
    m_mode = n_mode; m_cm = n_cm; m_idle = n_idle; m_wdt = n_wdt; m_res = n_res;
    m_rr = rst_e; m_wk = wake;
    chk(tag, "mode_state", int'(mode_state), int'(m_mode));
    chk(tag, "clk_mode", int'(clk_mode), int'(m_cm));
    chk(tag, "idle_sel", int'(idle_sel), int'(m_idle));
    chk(tag, "wdt_armed", int'(wdt_armed), int'(m_wdt));
    chk(tag, "restart_req", int'(restart_req), int'(m_rr));
    chk(tag, "wake_pulse", int'(wake_pulse), int'(m_wk));
    chk("R5", "resume_addr", int'(resume_addr), int'(m_res));
    chk("R9", "cpu_halt", int'(cpu_halt), int'(m_mode[1]));
    chk("R9", "lp_clk", int'(lp_clk), int'(m_mode[0]));
    if (m_rr) chk("R6", "restart_addr", int'(restart_addr), 0);
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [7:0] d,
                       input logic [3:0] irq, input logic ir, input logic er,
                       input logic wd, input logic [15:0] pc);
    wr_en = we; wr_sel = sel; wr_data = d; irq_req = irq;
    int_rst_req = ir; ext_rst_req = er; wdt_rst = wd; pc_next = pc;
    predict_and_step();
  endtask

  task automatic quiet();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    failures++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst_n = 0;
    #35;
    // R1 reset values while held
    chk("R1", "mode_state", int'(mode_state), 0);
    chk("R1", "cpu_halt", int'(cpu_halt), 0);
    chk("R1", "clk_mode", int'(clk_mode), 0);
    chk("R1", "wdt_armed", int'(wdt_armed), 1);
    chk("R1", "restart_req", int'(restart_req), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    m_mode = 0; m_cm = 0; m_idle = 0; m_wdt = 1; m_res = 0; m_rr = 0; m_wk = 0;
    chk("R1", "idle_sel", int'(idle_sel), 0);
    chk("R1", "wake_pulse", int'(wake_pulse), 0);

    // R2 plain idle, R8 write while halted, R4 wake to run
    drive(1, 0, 8'h00, 0, 0, 0, 0, 16'h1111);
    drive(1, 0, 8'h01, 0, 0, 0, 0, 16'h0123);
    drive(1, 1, 8'h44, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 4'b0100, 0, 0, 0, 0);
    quiet();
    // R3 low-power run, R2 low-power idle, R4 wake lands low-power, R3 zero write
    drive(1, 1, 8'h05, 0, 0, 0, 0, 0);
    drive(1, 0, 8'h01, 4'b0001, 0, 0, 0, 16'h0456);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 4'b1000, 0, 0, 0, 0);
    drive(1, 1, 8'h00, 0, 0, 0, 0, 0);
    // R7 disarm, stay idle through watchdog
    drive(1, 2, 8'h01, 0, 0, 0, 0, 0);
    drive(1, 2, 8'h00, 0, 0, 0, 0, 0);
    drive(1, 0, 8'h01, 0, 0, 0, 0, 16'h0789);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    // R6 reset beats simultaneous interrupt
    drive(0, 0, 0, 4'b0010, 0, 1, 0, 0);
    // R7 armed watchdog ends low-power idle
    drive(1, 1, 8'h09, 0, 0, 0, 0, 0);
    drive(1, 0, 8'h01, 0, 0, 0, 0, 16'h0abc);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    quiet();

    for (int i = 0; i < 4000; i++) begin
      logic we, ir, er, wd; logic [1:0] sel; logic [7:0] d; logic [3:0] irq;
      int r;
      r   = $urandom_range(0, 99);
      we  = ($urandom_range(0, 99) < 35);
      sel = 2'($urandom_range(0, 2));
      d   = ($urandom_range(0, 3) == 0) ? 8'($urandom) :
            (($urandom_range(0, 1) == 0) ? 8'h00 : 8'h01);
      irq = ($urandom_range(0, 99) < 12) ? 4'($urandom_range(1, 15)) : 4'h0;
      ir  = (r < 2);
      er  = (r >= 2 && r < 4);
      wd  = ($urandom_range(0, 99) < 4);
      drive(we, sel, d, irq, ir, er, wd, 16'($urandom));
    end
    quiet();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule